// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Background Refresh

This block connects a simple host request port to an asynchronous 64K x 1 dynamic memory array whose address pins are shared by row and column. The host presents a 16-bit address, a direction flag and one data bit under a valid/ready handshake. The controller splits the address into a row half and a column half and sends them one after the other on an 8-bit bus. The row half is strobed with an active-low row strobe and the column half with an active-low column strobe. It returns the read bit together with a one-cycle completion pulse.

Opening a row empties the cells into the array's column latches. For that reason every row cycle ends with a restore interval under the row strobe before the strobe is released, and is followed by a minimum precharge time. A host that keeps its burst-continue input high leaves the row open after an access. Later requests to the same row are then served by column strobes alone. A request to a different row, or a dropped burst-continue, closes the row. A refresh timer walks every row in turn with row-strobe-only cycles and takes priority at the next idle point. All phase lengths are derived from nanosecond parameters and the clock period.

Top module: `dram_seq_ctrl`

## Requirements
- R1: The row is the upper 8 address bits and the column is the lower 8. The row half is on `dram_addr` when `dram_ras_n` falls, and the column half is on it when `dram_cas_n` falls.
- R2: `dram_cas_n` is low only while `dram_ras_n` is low. The first column strobe of a row cycle falls at least T_ROW = ceil(ROW_OPEN_NS/CLK_PERIOD_NS) cycles after the row strobe falls (7 at defaults).
- R3: The column strobe stays low for at least T_COL cycles (2 at defaults). `rsp_done` is a one-cycle pulse in exactly the cycle in which `dram_cas_n` rises, and `rsp_rdata` then holds the bit read from the array.
- R4: For a write (`req_write`=1), `dram_we_n` is 0 and `dram_din` equals the write bit while the column strobe is low. For a read, `dram_we_n` stays 1. Data written can be read back.
- R5: After the last column strobe rises, the row strobe stays low for at least T_RST cycles (4 at defaults). Because of this restore, every row keeps its contents.
- R6: Between two row cycles the row strobe stays high for at least T_PRE cycles (5 at defaults).
- R7: With `req_burst`=1, a following request to the same row is served by a new column strobe without the row strobe rising. The column strobe stays high for at least T_CP = ceil((PAGE_CYCLE_NS-COL_ACCESS_NS)/CLK_PERIOD_NS) cycles between such strobes (2 at defaults).
- R8: An open row is closed (row strobe high) when a request with a different row arrives or when `req_burst` goes low. The new row is then opened by a full row cycle.
- R9: Refresh cycles strobe the row only, with no column strobe. They address rows 0, 1, 2, … in order, wrap from 255 to 0, and start no more than about T_REF cycles plus one access apart.
- R10: While a refresh is pending, `req_ready` is 0. A pending refresh closes an open page burst and is served before the next host request.
- R11: Out of reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `rsp_done` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Row in upper half, column in lower half |
| req_wdata | input | 1 | Write data bit |
| req_burst | input | 1 | Keep the row open after this access |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 1 | Read data bit |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to the array |
| dram_dout | input | 1 | Data from the array |

## Verification
The refresh timer can expire in the same cycle that a host request waits in idle, or while a page burst holds its row open. The bench provokes both cases. It holds a burst row open across a refresh interval, and it runs random traffic over a few rows with a short refresh interval so that the timer often lands on top of requests. The outcome is judged by three things: the refresh row sequence and spacing, the strobe timing seen by a destructive-read array model, and read-back data plus a final comparison of the whole array, which would expose a skipped restore.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_ACCESS,
    S_PAGE,
    S_RESTORE,
    S_PRECHG,
    S_REFRESH
  } phase_e;

  // Whole clock cycles covering a duration in ns, never less than one.
  function automatic int cycles_for(input int ns, input int period);
    int c;
    c = ns / period;
    if (c * period < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/drc_phase_timer.sv
module drc_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/drc_refresh_sched.sv
module drc_refresh_sched #(
  parameter int INTERVAL = 488,
  parameter int ROW_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             served,
  output logic             pending,
  output logic [ROW_W-1:0] row
);

  localparam int TW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);

  logic [TW-1:0] tick;
  logic          wrap;

  assign wrap = (tick == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick    <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      tick <= wrap ? '0 : tick + 1'b1;
      if (wrap)        pending <= 1'b1;
      else if (served) pending <= 1'b0;
      if (served)      row <= row + 1'b1;
    end
  end

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import drc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ROW_OPEN_NS   = 50,
  parameter int COL_ACCESS_NS = 10,
  parameter int RESTORE_NS    = 30,
  parameter int PRECHARGE_NS  = 40,
  parameter int PAGE_CYCLE_NS = 25,
  parameter int REFRESH_NS    = 3900,
  parameter int HALF_W        = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic                req_wdata,
  input  logic                req_burst,
  output logic                rsp_done,
  output logic                rsp_rdata,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_din,
  input  logic                dram_dout
);

  localparam int T_ROW = cycles_for(ROW_OPEN_NS, CLK_PERIOD_NS);
  localparam int T_COL = cycles_for(COL_ACCESS_NS, CLK_PERIOD_NS);
  localparam int T_RST = cycles_for(RESTORE_NS, CLK_PERIOD_NS);
  localparam int T_PRE = cycles_for(PRECHARGE_NS, CLK_PERIOD_NS);
  localparam int T_CP  = cycles_for(PAGE_CYCLE_NS - COL_ACCESS_NS, CLK_PERIOD_NS);
  localparam int T_REF = cycles_for(REFRESH_NS, CLK_PERIOD_NS);
  localparam int T_M1  = (T_ROW > T_COL) ? T_ROW : T_COL;
  localparam int T_M2  = (T_RST > T_PRE) ? T_RST : T_PRE;
  localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX = (T_M3 > T_CP) ? T_M3 : T_CP;
  localparam int TW    = $clog2(T_MAX + 1);

  // Timer reload value for a phase that lasts n cycles.
  function automatic logic [TW-1:0] span(input int n);
    return TW'(n - 1);
  endfunction

  phase_e              st, st_nx;
  logic [HALF_W-1:0]   row_q, col_q;
  logic                we_q, wd_q, burst_q;
  logic                rdata_q, done_q;
  logic                tmr_load, tmr_exp;
  logic [TW-1:0]       tmr_val;
  logic                ref_pending, ref_served;
  logic [HALF_W-1:0]   ref_row;
  logic                row_hit, accept, col_end;

  drc_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  drc_refresh_sched #(.INTERVAL(T_REF), .ROW_W(HALF_W)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .served  (ref_served),
    .pending (ref_pending),
    .row     (ref_row)
  );

  assign row_hit = (req_addr[2*HALF_W-1:HALF_W] == row_q);
  assign col_end = (st == S_ACCESS) && tmr_exp;

  always_comb begin
    st_nx      = st;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    accept     = 1'b0;
    ref_served = 1'b0;
    req_ready  = 1'b0;
    case (st)
      S_IDLE: begin
        if (ref_pending) begin
          st_nx = S_REFRESH; tmr_load = 1'b1; tmr_val = span(T_ROW);
        end else begin
          req_ready = 1'b1;
          if (req_valid) begin
            accept = 1'b1;
            st_nx = S_OPEN; tmr_load = 1'b1; tmr_val = span(T_ROW);
          end
        end
      end
      S_OPEN: if (tmr_exp) begin
        st_nx = S_ACCESS; tmr_load = 1'b1; tmr_val = span(T_COL);
      end
      S_ACCESS: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (burst_q) begin st_nx = S_PAGE;    tmr_val = span(T_CP);  end
        else         begin st_nx = S_RESTORE; tmr_val = span(T_RST); end
      end
      S_PAGE: if (tmr_exp) begin
        if (ref_pending) begin
          st_nx = S_RESTORE; tmr_load = 1'b1; tmr_val = span(T_RST);
        end else begin
          req_ready = row_hit;
          if (req_valid && row_hit) begin
            accept = 1'b1;
            st_nx = S_ACCESS; tmr_load = 1'b1; tmr_val = span(T_COL);
          end else if (req_valid || !req_burst) begin
            st_nx = S_RESTORE; tmr_load = 1'b1; tmr_val = span(T_RST);
          end
        end
      end
      S_RESTORE: if (tmr_exp) begin
        st_nx = S_PRECHG; tmr_load = 1'b1; tmr_val = span(T_PRE);
      end
      S_PRECHG: if (tmr_exp) st_nx = S_IDLE;
      S_REFRESH: if (tmr_exp) begin
        ref_served = 1'b1;
        st_nx = S_RESTORE; tmr_load = 1'b1; tmr_val = span(T_RST);
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      wd_q    <= 1'b0;
      burst_q <= 1'b0;
      rdata_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= col_end;
      if (col_end) rdata_q <= dram_dout;
      if (accept) begin
        row_q   <= req_addr[2*HALF_W-1:HALF_W];
        col_q   <= req_addr[HALF_W-1:0];
        we_q    <= req_write;
        wd_q    <= req_wdata;
        burst_q <= req_burst;
      end
    end
  end

  always_comb begin
    dram_ras_n = !(st inside {S_OPEN, S_ACCESS, S_PAGE, S_RESTORE, S_REFRESH});
    dram_cas_n = (st != S_ACCESS);
    dram_we_n  = !((st == S_ACCESS) && we_q);
    dram_din   = wd_q;
    if (st == S_REFRESH)     dram_addr = ref_row;
    else if (st == S_ACCESS) dram_addr = col_q;
    else                     dram_addr = row_q;
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
  parameter int T_ROW = 7,
  parameter int T_COL = 2,
  parameter int T_RST = 4,
  parameter int T_PRE = 5,
  parameter int T_CP  = 2,
  parameter int RW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          ref_pending,
  input logic          ref_served,
  input logic [RW-1:0] ref_row
);

  logic [7:0] lo_cnt, cas_lo, rst_cnt, pre_cnt, cp_cnt;
  logic       cas_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      cas_lo   <= '0;
      rst_cnt  <= '0;
      pre_cnt  <= 8'hFF;
      cp_cnt   <= 8'hFF;
      cas_seen <= 1'b0;
    end else begin
      if (ras_n) lo_cnt <= '0;
      else if (lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 1'b1;
      if (cas_n) cas_lo <= '0;
      else if (cas_lo != 8'hFF) cas_lo <= cas_lo + 1'b1;
      if (ras_n || !cas_n) rst_cnt <= '0;
      else if (rst_cnt != 8'hFF) rst_cnt <= rst_cnt + 1'b1;
      if (!ras_n) pre_cnt <= '0;
      else if (pre_cnt != 8'hFF) pre_cnt <= pre_cnt + 1'b1;
      if (!cas_n) cp_cnt <= '0;
      else if (cp_cnt != 8'hFF) cp_cnt <= cp_cnt + 1'b1;
      if (ras_n) cas_seen <= 1'b0;
      else if (!cas_n) cas_seen <= 1'b1;
    end
  end

  assert_cas_inside_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !cas_seen) |-> (lo_cnt >= 8'(T_ROW)));
  assert_cas_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (cas_lo >= 8'(T_COL)));
  assert_done_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> rsp_done);
  assert_done_only_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $rose(cas_n));
  assert_we_under_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n);
  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (rst_cnt >= 8'(T_RST)));
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (pre_cnt >= 8'(T_PRE)));
  assert_page_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && cas_seen) |-> (cp_cnt >= 8'(T_CP)));
  assert_ref_ras_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_served |-> (!ras_n && cas_n && !cas_seen));
  assert_ref_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_served |=> (ref_row == $past(ref_row) + 1'b1));
  assert_ref_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !ref_pending);

endmodule

bind dram_seq_ctrl drc_checker #(
  .T_ROW (T_ROW),
  .T_COL (T_COL),
  .T_RST (T_RST),
  .T_PRE (T_PRE),
  .T_CP  (T_CP),
  .RW    (HALF_W)
) u_drc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_n       (dram_ras_n),
  .cas_n       (dram_cas_n),
  .we_n        (dram_we_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .ref_pending (ref_pending),
  .ref_served  (ref_served),
  .ref_row     (ref_row)
);

// File: tb/dram_seq_ctrl_bench.sv
module dram_seq_ctrl_bench;

  localparam int PERIOD = 8;
  localparam int REF_NS = 800;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int T_ROW = cyc_of(50);
  localparam int T_COL = cyc_of(10);
  localparam int T_RST = cyc_of(30);
  localparam int T_PRE = cyc_of(40);
  localparam int T_CP  = cyc_of(25 - 10);
  localparam int T_REF = cyc_of(REF_NS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0, req_burst = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_done, rsp_rdata;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
  logic        dram_dout = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dram_seq_ctrl #(.CLK_PERIOD_NS(PERIOD), .REFRESH_NS(REF_NS)) u_dram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_burst(req_burst), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_din(dram_din), .dram_dout(dram_dout)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [255:0] mem [256];
  logic [255:0] shadow [256];
  logic [255:0] latch;
  logic [7:0]   open_row, exp_row, exp_col, exp_ref = 8'd0;
  logic         exp_we = 1'b0, exp_wd = 1'b0;
  int ref_count = 0, data_opens = 0;
  int hi_cnt = 1000, lo_cnt = 0, cas_lo = 0, cp_cnt = 1000, since_cas = 0;
  int fall_cyc = 0, last_ref_fall = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      miscompares++;
      $display("FAIL R0 watchdog: actual %0d cycles expected fewer than %0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // Destructive-read array model and strobe timing monitor.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1; hi_cnt = 1000; cp_cnt = 1000;
    end else begin
      if (prev_ras && !dram_ras_n) begin
        chk(hi_cnt >= T_PRE, "R6", "precharge cycles", hi_cnt, T_PRE);
        open_row = dram_addr;
        latch = mem[open_row];
        mem[open_row] = ~mem[open_row];
        saw_cas = 1'b0; lo_cnt = 0; since_cas = 0; fall_cyc = cyc;
      end
      if (!dram_ras_n && prev_cas && !dram_cas_n) begin
        if (!saw_cas) begin
          chk(lo_cnt >= T_ROW, "R2", "row-to-column cycles", lo_cnt, T_ROW);
          data_opens++;
        end else begin
          chk(cp_cnt >= T_CP, "R7", "page column precharge", cp_cnt, T_CP);
        end
        chk(open_row == exp_row && dram_addr == exp_col, "R1", "row/column",
            {open_row, dram_addr}, {exp_row, exp_col});
        if (exp_we) begin
          chk(!dram_we_n && dram_din == exp_wd, "R4", "write strobe/data",
              {dram_we_n, dram_din}, {1'b0, exp_wd});
          latch[dram_addr] = dram_din;
        end else begin
          chk(dram_we_n, "R4", "read keeps we_n high", dram_we_n, 1);
        end
        saw_cas = 1'b1; cas_lo = 0;
        dram_dout = latch[dram_addr];
      end
      if (!prev_cas && dram_cas_n)
        chk(cas_lo >= T_COL, "R3", "column strobe width", cas_lo, T_COL);
      if (!prev_ras && dram_ras_n) begin
        chk(since_cas >= T_RST, "R5", "restore cycles", since_cas, T_RST);
        if (!saw_cas) begin
          chk(open_row == exp_ref, "R9", "refresh row", open_row, exp_ref);
          if (ref_count > 0)
            chk(fall_cyc - last_ref_fall <= T_REF + 40, "R9", "refresh spacing",
                fall_cyc - last_ref_fall, T_REF + 40);
          last_ref_fall = fall_cyc;
          exp_ref = exp_ref + 8'd1;
          ref_count++;
        end
        mem[open_row] = latch;
        hi_cnt = 0;
      end
      if (dram_ras_n) hi_cnt++;
      if (!dram_ras_n && dram_cas_n && !saw_cas) lo_cnt++;
      if (!dram_cas_n) cas_lo++;
      if (dram_cas_n) cp_cnt++; else cp_cnt = 0;
      if (!dram_cas_n) since_cas = 0;
      else if (!dram_ras_n) since_cas++;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
    end
  end

  task automatic do_req(input logic wr, input logic [15:0] a, input logic wd,
                        input logic burst, input string tag);
    exp_row = a[15:8]; exp_col = a[7:0]; exp_we = wr; exp_wd = wd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_burst = burst;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    while (!rsp_done) begin @(negedge clk); #1; end
    if (wr) shadow[a[15:8]][a[7:0]] = wd;
    else chk(rsp_rdata == shadow[a[15:8]][a[7:0]], tag, "read data",
             rsp_rdata, shadow[a[15:8]][a[7:0]]);
  endtask

  task automatic wait_ref();
    int c0;
    c0 = ref_count;
    while (ref_count == c0) @(negedge clk);
  endtask

  initial begin
    int o0, r0, bad;
    logic [7:0] rows [4];
    rows[0] = 8'h10; rows[1] = 8'h11; rows[2] = 8'hA7; rows[3] = 8'hFF;
    void'($urandom(32'd20240611));
    for (int r = 0; r < 256; r++)
      for (int w = 0; w < 8; w++) begin
        mem[r][w*32 +: 32] = $urandom;
        shadow[r][w*32 +: 32] = mem[r][w*32 +: 32];
      end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R11", "strobes idle",
        {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(!rsp_done, "R11", "done low", rsp_done, 0);
    chk(req_ready, "R11", "ready high", req_ready, 1);

    // R4 / R3 single write then read
    do_req(1'b1, 16'h1234, ~shadow[8'h12][8'h34], 1'b0, "R4");
    do_req(1'b0, 16'h1234, 1'b0, 1'b0, "R4");
    do_req(1'b0, 16'hFF00, 1'b0, 1'b0, "R3");

    // R7 page burst on one row: one row open only
    wait_ref();
    o0 = data_opens;
    do_req(1'b1, 16'h4001, 1'b1, 1'b1, "R7");
    do_req(1'b1, 16'h4002, 1'b0, 1'b1, "R7");
    do_req(1'b1, 16'h4003, 1'b1, 1'b1, "R7");
    do_req(1'b0, 16'h4002, 1'b0, 1'b1, "R7");
    do_req(1'b0, 16'h4001, 1'b0, 1'b0, "R7");
    chk(data_opens - o0 == 1, "R7", "row opens in burst", data_opens - o0, 1);

    // R8 row change closes and reopens
    wait_ref();
    o0 = data_opens;
    do_req(1'b0, 16'h5007, 1'b0, 1'b1, "R8");
    do_req(1'b0, 16'h5107, 1'b0, 1'b0, "R8");
    chk(data_opens - o0 == 2, "R8", "row opens on row change", data_opens - o0, 2);
    // R8 dropping burst-continue closes the row
    wait_ref();
    do_req(1'b1, 16'h5209, 1'b1, 1'b1, "R8");
    repeat (3) @(negedge clk);
    chk(!dram_ras_n, "R8", "row held open under burst", dram_ras_n, 0);
    req_burst = 1'b0;
    repeat (12) @(negedge clk);
    chk(dram_ras_n, "R8", "row closed after burst drop", dram_ras_n, 1);

    // R10 refresh pending while a page is held open
    do_req(1'b0, 16'h6011, 1'b0, 1'b1, "R10");
    r0 = ref_count;
    repeat (2 * T_REF) @(negedge clk);
    chk(ref_count > r0, "R10", "refresh served during page hold", ref_count - r0, 1);
    wait_ref();
    repeat (12) @(negedge clk);
    chk(dram_ras_n, "R10", "page closed by refresh", dram_ras_n, 1);
    do_req(1'b0, 16'h6011, 1'b0, 1'b0, "R10");

    // Random traffic over a few rows, mixing page hits and row changes
    for (int i = 0; i < 500; i++) begin
      logic [15:0] a;
      a = {rows[$urandom % 4], 8'($urandom)};
      do_req(1'($urandom), a, 1'($urandom), 1'($urandom), "R4");
      repeat ($urandom % 3) @(negedge clk);
    end
    req_burst = 1'b0;

    // R9 walk all rows and wrap
    while (ref_count < 260) @(negedge clk);
    chk(ref_count >= 257 && exp_ref == 8'(ref_count), "R9", "refresh wrap count",
        ref_count, 257);

    // R5 every row intact after all closes
    repeat (40) @(negedge clk);
    bad = 0;
    for (int r = 0; r < 256; r++) if (mem[r] !== shadow[r]) bad++;
    chk(bad == 0, "R5", "rows differing from expected", bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule